// File: doc/BRIEF.md
# Macro Result Dispatch Unit

Each instruction of a small macro engine produces one value. This unit takes that value and decides where it goes. A three-bit result-operation code picks one of eight routes. The route sets what the destination register receives: either the computed value or a word popped from the parameter FIFO. It also sets whether the unit loads the method register, and whether it emits a method write to the downstream engine.

The method register packs a 12-bit target address and a 6-bit step. Every method write uses the current address and then moves the address forward by the step, with wrap-around. A caller can therefore stream a run of writes to consecutive or strided targets after one load.

The unit accepts one operation per cycle. Register writes, method writes and the underflow flag are registered and appear one cycle after the operation is presented. The FIFO pop is combinational, on the same cycle as the operation.

Top module: `mrd_dispatch`

## Requirements
- R1: When `op_valid` is high, `rf_we` is high one cycle later, with `rf_waddr` equal to `op_dst`. When `op_valid` is low, no register write, method write, FIFO pop or error follows.
- R2: The value written to the register follows the operation code. Codes 1, 2, 4, 6 and 7 write `op_result`. Codes 0, 3 and 5 write the fetched parameter and discard `op_result`.
- R3: Codes 0, 3, 5 and 6 fetch a parameter. While the FIFO is non-empty, such a fetch raises `prm_rd` in the same cycle and takes `prm_data` from that cycle. No other code raises `prm_rd`.
- R4: A fetch while `prm_empty` is high does not raise `prm_rd`. It raises `err_underflow` for one cycle, one cycle later, and uses zero as the fetched value.
- R5: Codes 2, 5, 6 and 7 load the method register from `op_result`: bits 11:0 become the address and bits 17:12 become the step. Codes 0, 1, 3 and 4 leave the method register unchanged.
- R6: Codes 3, 4, 6 and 7 produce `mw_valid` one cycle later. The data is `op_result` for codes 3 and 4, the fetched parameter for code 6, and bits 17:12 of `op_result`, zero-extended, for code 7. Codes 0, 1, 2 and 5 produce no method write.
- R7: Codes 6 and 7 load the method register before they send, so their write goes to `op_result[11:0]`. Codes 3 and 4 write to the address currently held.
- R8: After every method write, the held address increases by the held step, modulo 4096. The step itself is kept.
- R9: While `rst_n` is low at a clock edge, every output register clears and the method register resets to address 0 and step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Result-operation code, 0 to 7 |
| op_dst | input | 3 | Destination register index |
| op_result | input | 32 | Value computed by the instruction |
| prm_empty | input | 1 | Parameter FIFO holds no word |
| prm_data | input | 32 | Head word of the parameter FIFO |
| prm_rd | output | 1 | Pop the FIFO head this cycle |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 32 | Register write value |
| mw_valid | output | 1 | Method write valid |
| mw_addr | output | 12 | Method write address |
| mw_data | output | 32 | Method write data |
| err_underflow | output | 1 | A fetch found the FIFO empty |

## Verification
Two functions land in the same cycle for codes 6 and 7: the method-register load and the send that must already use the new address. A single operation therefore has to hand the freshly loaded address to the write and also post-increment it. The bench sweeps every code against FIFO-empty and FIFO-full and against results with different address and step fields, including an address near 4095. An arithmetic model of the method register, built from the requirements, predicts each write's address and the address of the following write. That follow-up write checks that the load and the increment were both applied in the right order.

// File: rtl/mrd_pkg.sv
// Shared types for the macro result dispatch unit.
// Assumes the 3-bit operation code encoding listed in the brief.
package mrd_pkg;

    typedef enum logic [2:0] {
        OP_FETCH_KEEP  = 3'd0,
        OP_MOVE        = 3'd1,
        OP_MOVE_LOAD   = 3'd2,
        OP_FETCH_SEND  = 3'd3,
        OP_MOVE_SEND   = 3'd4,
        OP_FETCH_LOAD  = 3'd5,
        OP_LOAD_PSEND  = 3'd6,
        OP_LOAD_STSEND = 3'd7
    } res_op_e;

    typedef enum logic [1:0] {
        SD_RESULT = 2'd0,
        SD_PARAM  = 2'd1,
        SD_STEP   = 2'd2
    } send_src_e;

    typedef struct packed {
        logic      fetch;     // pop one parameter
        logic      wr_param;  // register receives the parameter
        logic      load;      // load method register from result
        logic      send;      // emit a method write
        send_src_e src;       // method write data source
    } ctl_t;

endpackage

// File: rtl/mrd_decode.sv
// Operation decoder: maps a result-operation code to control flags.
// Purely combinational; assumes the code is only acted on when valid.
module mrd_decode
    import mrd_pkg::*;
(
    input  res_op_e op,
    output ctl_t    ctl
);

    // Translate the code into fetch/write/load/send controls.
    always_comb begin
        ctl = '{fetch: 1'b0, wr_param: 1'b0, load: 1'b0, send: 1'b0, src: SD_RESULT};
        unique case (op)
            OP_FETCH_KEEP:  begin ctl.fetch = 1'b1; ctl.wr_param = 1'b1; end
            OP_MOVE:        ;
            OP_MOVE_LOAD:   ctl.load = 1'b1;
            OP_FETCH_SEND:  begin ctl.fetch = 1'b1; ctl.wr_param = 1'b1; ctl.send = 1'b1; end
            OP_MOVE_SEND:   ctl.send = 1'b1;
            OP_FETCH_LOAD:  begin ctl.fetch = 1'b1; ctl.wr_param = 1'b1; ctl.load = 1'b1; end
            OP_LOAD_PSEND:  begin
                ctl.fetch = 1'b1; ctl.load = 1'b1; ctl.send = 1'b1; ctl.src = SD_PARAM;
            end
            OP_LOAD_STSEND: begin ctl.load = 1'b1; ctl.send = 1'b1; ctl.src = SD_STEP; end
            default:        ;
        endcase
    end

endmodule

// File: rtl/mrd_param_fetch.sv
// Parameter fetch: pops a show-ahead FIFO when a fetch is requested.
// Assumes prm_data is valid whenever prm_empty is low; yields zero on underflow.
module mrd_param_fetch #(
    parameter int DATA_W = 32
) (
    input  logic              req,
    input  logic              prm_empty,
    input  logic [DATA_W-1:0] prm_data,
    output logic              prm_rd,
    output logic [DATA_W-1:0] value,
    output logic              underflow
);

    // Pop only when a word is present; otherwise flag underflow.
    always_comb begin
        prm_rd    = req && !prm_empty;
        underflow = req && prm_empty;
        value     = prm_rd ? prm_data : '0;
    end

endmodule

// File: rtl/mrd_method_reg.sv
// Method register: holds a target address and a step field.
// A load takes effect before a send in the same cycle; each send
// post-increments the address by the step, wrapping at the address width.
module mrd_method_reg #(
    parameter int ADDR_W = 12,
    parameter int STEP_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [ADDR_W+STEP_W-1:0] load_val,
    input  logic                     send,
    output logic [ADDR_W-1:0]        eff_addr,
    output logic [STEP_W-1:0]        eff_step
);

    logic [ADDR_W-1:0] addr_q;
    logic [STEP_W-1:0] step_q;

    // Choose the address/step in effect this cycle (loaded value wins).
    always_comb begin
        eff_addr = load ? load_val[ADDR_W-1:0] : addr_q;
        eff_step = load ? load_val[ADDR_W+STEP_W-1:ADDR_W] : step_q;
    end

    // Commit a load and/or the post-send increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            step_q <= '0;
        end else if (load || send) begin
            step_q <= eff_step;
            addr_q <= send ? eff_addr + ADDR_W'(eff_step) : eff_addr;
        end
    end

endmodule

// File: rtl/mrd_dispatch.sv
// Macro result dispatch unit (top).
// Routes an instruction result to the register write port and/or the
// method write port per a 3-bit code. Outputs register one cycle after the
// operation; the FIFO pop is combinational. Assumes DATA_W >= ADDR_W+STEP_W.
module mrd_dispatch
    import mrd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int STEP_W = 6,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [REG_AW-1:0] op_dst,
    input  logic [DATA_W-1:0] op_result,
    input  logic              prm_empty,
    input  logic [DATA_W-1:0] prm_data,
    output logic              prm_rd,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              mw_valid,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [DATA_W-1:0] mw_data,
    output logic              err_underflow
);

    localparam int MW = ADDR_W + STEP_W;

    ctl_t              ctl;
    logic [DATA_W-1:0] prm_val;
    logic              uflow;
    logic [ADDR_W-1:0] eff_addr;
    logic [STEP_W-1:0] eff_step;
    logic [DATA_W-1:0] send_data;
    logic [DATA_W-1:0] reg_data;

    mrd_decode u_dec (
        .op  (res_op_e'(op_code)),
        .ctl (ctl)
    );

    mrd_param_fetch #(.DATA_W(DATA_W)) u_fetch (
        .req       (op_valid && ctl.fetch),
        .prm_empty (prm_empty),
        .prm_data  (prm_data),
        .prm_rd    (prm_rd),
        .value     (prm_val),
        .underflow (uflow)
    );

    mrd_method_reg #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_mreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (op_valid && ctl.load),
        .load_val (op_result[MW-1:0]),
        .send     (op_valid && ctl.send),
        .eff_addr (eff_addr),
        .eff_step (eff_step)
    );

    // Select register write data and method write data.
    always_comb begin
        reg_data = ctl.wr_param ? prm_val : op_result;
        unique case (ctl.src)
            SD_PARAM: send_data = prm_val;
            SD_STEP:  send_data = DATA_W'(eff_step);
            default:  send_data = op_result;
        endcase
    end

    // Register all outward results one cycle after the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we         <= 1'b0;
            rf_waddr      <= '0;
            rf_wdata      <= '0;
            mw_valid      <= 1'b0;
            mw_addr       <= '0;
            mw_data       <= '0;
            err_underflow <= 1'b0;
        end else begin
            rf_we         <= op_valid;
            mw_valid      <= op_valid && ctl.send;
            err_underflow <= uflow;
            if (op_valid) begin
                rf_waddr <= op_dst;
                rf_wdata <= reg_data;
            end
            if (op_valid && ctl.send) begin
                mw_addr <= eff_addr;
                mw_data <= send_data;
            end
        end
    end

endmodule

// File: rtl/mrd_dispatch_chk.sv
// Assertion checker for mrd_dispatch, bound to every instance.
module mrd_dispatch_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int STEP_W = 6,
    parameter int REG_AW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic [REG_AW-1:0] op_dst,
    input logic [DATA_W-1:0] op_result,
    input logic              prm_empty,
    input logic [DATA_W-1:0] prm_data,
    input logic              prm_rd,
    input logic              rf_we,
    input logic [REG_AW-1:0] rf_waddr,
    input logic [DATA_W-1:0] rf_wdata,
    input logic              mw_valid,
    input logic [ADDR_W-1:0] mw_addr,
    input logic [DATA_W-1:0] mw_data,
    input logic              err_underflow
);

    logic is_fetch;
    logic is_send;
    assign is_fetch = op_valid && (op_code inside {3'd0, 3'd3, 3'd5, 3'd6});
    assign is_send  = op_valid && (op_code inside {3'd3, 3'd4, 3'd6, 3'd7});

    p_write_follows_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (rf_we && rf_waddr == $past(op_dst)));
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!rf_we && !mw_valid && !err_underflow));
    p_pop_when_avail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prm_rd == (is_fetch && !prm_empty));
    p_underflow_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fetch && prm_empty) |=> err_underflow);
    p_send_follows_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_send |=> mw_valid);
    p_step_send_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd7) |=>
        (mw_addr == $past(op_result[ADDR_W-1:0]) &&
         mw_data == DATA_W'($past(op_result[ADDR_W+STEP_W-1:ADDR_W]))));

endmodule

bind mrd_dispatch mrd_dispatch_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W), .REG_AW(REG_AW)
) u_chk (.*);

// File: tb/mrd_dispatch_tb.sv
// Sweep bench for mrd_dispatch with an arithmetic model of the method register.
module mrd_dispatch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [2:0]  op_dst = '0;
    logic [31:0] op_result = '0;
    logic        prm_empty = 1'b1;
    logic [31:0] prm_data = '0;
    logic        prm_rd;
    logic        rf_we;
    logic [2:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        mw_valid;
    logic [11:0] mw_addr;
    logic [31:0] mw_data;
    logic        err_underflow;

    int n_chk = 0;
    int n_bad = 0;
    logic [11:0] m_addr = '0;
    logic [5:0]  m_step = '0;

    mrd_dispatch u_dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [2:0] dst, input logic [31:0] res,
                          input logic empty, input logic [31:0] pdat);
        logic fetch, from_prm, load, send;
        logic [31:0] fv, wexp, dexp;
        logic [11:0] sa;
        logic [5:0]  ss;
        fetch    = op inside {3'd0, 3'd3, 3'd5, 3'd6};
        from_prm = op inside {3'd0, 3'd3, 3'd5};
        load     = op inside {3'd2, 3'd5, 3'd6, 3'd7};
        send     = op inside {3'd3, 3'd4, 3'd6, 3'd7};
        fv       = (fetch && !empty) ? pdat : 32'd0;
        wexp     = from_prm ? fv : res;
        sa       = load ? res[11:0] : m_addr;
        ss       = load ? res[17:12] : m_step;
        dexp     = (op == 3'd6) ? fv : (op == 3'd7) ? {26'd0, res[17:12]} : res;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_dst = dst; op_result = res;
        prm_empty = empty; prm_data = pdat;
        #1;
        chk("R3", "prm_rd", {31'd0, prm_rd}, {31'd0, fetch && !empty});
        @(negedge clk);
        chk("R1", "rf_we", {31'd0, rf_we}, 32'd1);
        chk("R1", "rf_waddr", {29'd0, rf_waddr}, {29'd0, dst});
        chk("R2", "rf_wdata", rf_wdata, wexp);
        chk("R4", "err_underflow", {31'd0, err_underflow}, {31'd0, fetch && empty});
        chk("R6", "mw_valid", {31'd0, mw_valid}, {31'd0, send});
        if (send) begin
            chk("R7", "mw_addr", {20'd0, mw_addr}, {20'd0, sa});
            chk("R6", "mw_data", mw_data, dexp);
        end
        m_addr = send ? sa + 12'(ss) : sa;
        m_step = ss;
        op_valid = 1'b0; prm_empty = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] vals [4];
        vals[0] = 32'hA5A3_5FFE; vals[1] = 32'h0000_2010; vals[2] = 32'h1234_0FFF; vals[3] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk("R9", "rf_we", {31'd0, rf_we}, 32'd0);
        chk("R9", "mw_valid", {31'd0, mw_valid}, 32'd0);
        chk("R9", "err_underflow", {31'd0, err_underflow}, 32'd0);
        chk("R9", "rf_wdata", rf_wdata, 32'd0);
        rst_n = 1'b1;
        // R9: first send uses reset address 0 and step 0 (R8 keeps it at 0)
        run_op(3'd4, 3'd1, 32'h0000_7777, 1'b1, 32'd0);
        run_op(3'd4, 3'd2, 32'h0000_8888, 1'b1, 32'd0);
        // Idle cycle: no activity (R1)
        @(negedge clk);
        chk("R1", "idle rf_we", {31'd0, rf_we}, 32'd0);
        chk("R1", "idle mw_valid", {31'd0, mw_valid}, 32'd0);
        // Full sweep over codes, FIFO state and result patterns (R2-R8)
        for (int v = 0; v < 4; v++)
            for (int e = 0; e < 2; e++)
                for (int op = 0; op < 8; op++) begin
                    run_op(3'(op), 3'(op + v), vals[v] ^ 32'(op), e[0], 32'hC0DE_0000 + 32'(op * 16 + v));
                    // R5/R8: a following plain send exposes the held address
                    run_op(3'd4, 3'd7, 32'h0BAD_0000 + 32'(op), 1'b1, 32'd0);
                end
        // R8: wrap at 4096 with step 3 starting from 0xFFE
        run_op(3'd2, 3'd3, 32'h0000_3FFE, 1'b1, 32'd0);
        run_op(3'd3, 3'd3, 32'h0000_0001, 1'b0, 32'h0000_0055);
        run_op(3'd4, 3'd3, 32'h0000_0002, 1'b1, 32'd0);
        run_op(3'd4, 3'd3, 32'h0000_0003, 1'b1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule